// File: doc/BRIEF.md
# Byte-Lane Strobe Decoder for a x16 Paged DRAM

This block decodes the control strobes of a sixteen-bit paged DRAM that has two column strobes, one per byte lane. It oversamples the asynchronous active-low row strobe, the two lane column strobes, the write enable and the output enable on a fast system clock. Each strobe first passes through a synchronizer chain. All decisions are then taken on edges seen in the synchronized domain.

From these edges the block derives a merged column strobe and, for each lane, an output-drive enable and a one-cycle write-capture pulse. It also reports a cycle classification and flags an illegal mix of write timings across the two lanes. The storage array, address latches and pad drivers sit next to this decoder and use its outputs.

Top module: `fpmx_decoder`

## Requirements
- R1: `cas_int` is high while at least one lane strobe is asserted. It goes high when the first lane strobe falls and drops only after the last one has risen.
- R2: Lane 0 (`lane_oe[0]`, `lane_wr[0]`, data bits 7:0) follows `casl_n`, and lane 1 (bit 1 of each, data bits 15:8) follows `cash_n`. One strobe gives a byte access and both strobes give a word access.
- R3: A lane's `lane_wr` bit pulses high for exactly one cycle at the later of two events: the lane strobe falling or WE# falling. A falling lane strobe counts only when the row was already open, meaning RAS# was sampled low both in that sample and in the one before.
- R4: If WE# is already low when a lane strobe falls, that lane is an early write. Its `lane_oe` bit stays low until the lane strobe rises.
- R5: If WE# is high when a lane strobe falls, that lane is a read and drives while OE# is low. A later WE# fall turns the lane into a read-write: the lane keeps driving and `cyc_type` moves from READ to RD_WR.
- R6: A lane's `lane_oe` bit is low whenever its lane strobe is high or OE# is high. A strobe fall with no open row never enables the lane.
- R7: `mode_err` is high while both lanes hold a mode and exactly one of the two is an early write.
- R8: `cyc_type` is IDLE (0) while RAS# is high. When RAS# falls it becomes RAS_ONLY (4) if no lane strobe is asserted, or CBR (5) if one is. CBR holds until RAS# rises, even if lane strobes toggle meanwhile.
- R9: In an open non-CBR row, each fall of the merged strobe sets `cyc_type` to READ (1) if WE# is high or EARLY_WR (2) if WE# is low. A WE# fall during READ while the merged strobe stays low gives RD_WR (3).
- R10: Every output reflects a pin change three clock edges later: two synchronizer stages plus one decision register.
- R11: After reset, all outputs are zero and `cyc_type` is IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| casl_n | input | 1 | Lower-lane column strobe, active low |
| cash_n | input | 1 | Upper-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| cas_int | output | 1 | Merged column strobe, active high |
| lane_oe | output | 2 | Per-lane output drive enable |
| lane_wr | output | 2 | Per-lane write-capture pulse |
| cyc_type | output | 3 | Cycle class: 0 IDLE, 1 READ, 2 EARLY_WR, 3 RD_WR, 4 RAS_ONLY, 5 CBR |
| mode_err | output | 1 | Mixed early/late write across lanes |

## Verification
The bench targets the orderings where the two lane strobes and WE# cross one another. If WE# falls between the two lane falls, a design that judges write timing only from the merged strobe misses `mode_err`. If a lane is released while the other is still held, a design that ends the merged strobe on the first rise drops `cas_int` too early. In hidden refresh, RAS# toggles while a lane is held low: a design that clears lane state on RAS# instead of on the lane strobe kills the read drive. A strobe that falls together with RAS# must classify as CBR and open no lane.

// File: rtl/fpmx_pkg.sv
package fpmx_pkg;

    // number of byte lanes served by separate column strobes
    localparam int NUM_LANES = 2;

    // synchronized strobes, active high after inversion
    typedef struct packed {
        logic ras;
        logic cas_hi;
        logic cas_lo;
        logic we;
        logic oe;
    } strb_t;

    localparam int STRB_W = $bits(strb_t);

    typedef enum logic [1:0] {
        LM_IDLE  = 2'd0,
        LM_READ  = 2'd1,
        LM_EARLY = 2'd2,
        LM_LATE  = 2'd3
    } lane_mode_e;

    typedef enum logic [2:0] {
        CY_IDLE     = 3'd0,
        CY_READ     = 3'd1,
        CY_EARLY_WR = 3'd2,
        CY_RD_WR    = 3'd3,
        CY_RAS_ONLY = 3'd4,
        CY_CBR      = 3'd5
    } cyc_e;

    function automatic logic went_active(input logic now_v, input logic was_v);
        return now_v & ~was_v;
    endfunction

    // a lane in read or read-write mode may drive its byte
    function automatic logic lane_may_drive(input lane_mode_e m);
        return (m == LM_READ) || (m == LM_LATE);
    endfunction

    // both lanes active but only one of them an early write
    function automatic logic modes_conflict(input lane_mode_e a, input lane_mode_e b);
        return (a != LM_IDLE) && (b != LM_IDLE) &&
               ((a == LM_EARLY) != (b == LM_EARLY));
    endfunction

endpackage

// File: rtl/fpmx_sync.sv
module fpmx_sync #(
    parameter int              WIDTH   = 5,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // shift chain; the last stage is the only one used downstream
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/fpmx_lane.sv
module fpmx_lane
    import fpmx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lane_now,
    input  logic       lane_was,
    input  logic       row_open,
    input  logic       we_now,
    input  logic       we_was,
    input  logic       oe_now,
    output lane_mode_e mode_q,
    output logic       drive_q,
    output logic       strobe_q
);
    lane_mode_e mode_nxt;
    logic       strobe_nxt;
    logic       lane_fell;
    logic       we_fell;

    assign lane_fell = went_active(lane_now, lane_was);
    assign we_fell   = went_active(we_now, we_was);

    always_comb begin
        mode_nxt   = mode_q;
        strobe_nxt = 1'b0;
        if (!lane_now) begin
            mode_nxt = LM_IDLE;
        end else if (lane_fell) begin
            if (!row_open) begin
                mode_nxt = LM_IDLE;
            end else if (we_now) begin
                mode_nxt   = LM_EARLY;   // data captured on the strobe edge
                strobe_nxt = 1'b1;
            end else begin
                mode_nxt = LM_READ;
            end
        end else if (mode_q == LM_READ && we_fell) begin
            mode_nxt   = LM_LATE;        // data captured on the WE edge
            strobe_nxt = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= LM_IDLE;
            drive_q  <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            mode_q   <= mode_nxt;
            drive_q  <= lane_now & oe_now & lane_may_drive(mode_nxt);
            strobe_q <= strobe_nxt;
        end
    end

endmodule

// File: rtl/fpmx_classify.sv
module fpmx_classify
    import fpmx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ras_now,
    input  logic ras_was,
    input  logic cas_now,
    input  logic cas_was,
    input  logic we_now,
    input  logic we_was,
    output cyc_e cyc_q
);
    cyc_e cyc_nxt;

    always_comb begin
        cyc_nxt = cyc_q;
        case ({ras_now, ras_was})
            2'b00, 2'b01: cyc_nxt = CY_IDLE;
            2'b10:        cyc_nxt = cas_now ? CY_CBR : CY_RAS_ONLY;
            default: begin
                if (cyc_q != CY_CBR && went_active(cas_now, cas_was)) begin
                    cyc_nxt = we_now ? CY_EARLY_WR : CY_READ;
                end else if (cyc_q == CY_READ && cas_now && cas_was &&
                             went_active(we_now, we_was)) begin
                    cyc_nxt = CY_RD_WR;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cyc_q <= CY_IDLE;
        else     cyc_q <= cyc_nxt;
    end

endmodule

// File: rtl/fpmx_decoder.sv
module fpmx_decoder
    import fpmx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ras_n,
    input  logic                 casl_n,
    input  logic                 cash_n,
    input  logic                 we_n,
    input  logic                 oe_n,
    output logic                 cas_int,
    output logic [NUM_LANES-1:0] lane_oe,
    output logic [NUM_LANES-1:0] lane_wr,
    output logic [2:0]           cyc_type,
    output logic                 mode_err
);
    logic [STRB_W-1:0]    pins_n;
    logic [STRB_W-1:0]    sync_n;
    strb_t                cur;
    strb_t                prv;
    logic [NUM_LANES-1:0] lane_now;
    logic [NUM_LANES-1:0] lane_was;
    logic                 row_open;
    logic                 cas_q;
    lane_mode_e           lane_mode [NUM_LANES];
    cyc_e                 cyc_q;

    assign pins_n = {ras_n, cash_n, casl_n, we_n, oe_n};

    fpmx_sync #(
        .WIDTH  (STRB_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL({STRB_W{1'b1}})
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_n),
        .q   (sync_n)
    );

    assign cur = strb_t'(~sync_n);

    // previous synchronized sample for edge detection
    always_ff @(posedge clk) begin
        if (rst) prv <= '0;
        else     prv <= cur;
    end

    assign lane_now = {cur.cas_hi, cur.cas_lo};
    assign lane_was = {prv.cas_hi, prv.cas_lo};
    assign row_open = cur.ras & prv.ras;

    // merged strobe: any lane asserted
    always_ff @(posedge clk) begin
        if (rst) cas_q <= 1'b0;
        else     cas_q <= |lane_now;
    end

    generate
        for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
            fpmx_lane u_lane (
                .clk      (clk),
                .rst      (rst),
                .lane_now (lane_now[i]),
                .lane_was (lane_was[i]),
                .row_open (row_open),
                .we_now   (cur.we),
                .we_was   (prv.we),
                .oe_now   (cur.oe),
                .mode_q   (lane_mode[i]),
                .drive_q  (lane_oe[i]),
                .strobe_q (lane_wr[i])
            );
        end
    endgenerate

    fpmx_classify u_class (
        .clk     (clk),
        .rst     (rst),
        .ras_now (cur.ras),
        .ras_was (prv.ras),
        .cas_now (|lane_now),
        .cas_was (|lane_was),
        .we_now  (cur.we),
        .we_was  (prv.we),
        .cyc_q   (cyc_q)
    );

    assign cas_int  = cas_q;
    assign cyc_type = cyc_q;
    assign mode_err = modes_conflict(lane_mode[0], lane_mode[1]);

endmodule

// File: rtl/fpmx_decoder_chk.sv
module fpmx_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       cas_int,
    input logic [1:0] lane_oe,
    input logic [1:0] lane_wr,
    input logic [2:0] cyc_type,
    input logic       mode_err
);
    // R6
    lane_oe_needs_cas_chk: assert property (@(posedge clk) disable iff (rst)
        (|lane_oe) |-> cas_int);

    // R3
    wr_lo_single_chk: assert property (@(posedge clk) disable iff (rst)
        lane_wr[0] |=> !lane_wr[0]);

    // R3
    wr_hi_single_chk: assert property (@(posedge clk) disable iff (rst)
        lane_wr[1] |=> !lane_wr[1]);

    // R8
    cbr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_type == 3'd5) |=> (cyc_type == 3'd5 || cyc_type == 3'd0));

    // R8
    idle_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_type == 3'd0) |=> (cyc_type == 3'd0 || cyc_type == 3'd4 || cyc_type == 3'd5));

    // R5
    rdwr_from_read_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cyc_type == 3'd3) |-> $past(cyc_type) == 3'd1);

    // R7
    err_needs_cas_chk: assert property (@(posedge clk) disable iff (rst)
        mode_err |-> cas_int);

endmodule

bind fpmx_decoder fpmx_decoder_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cas_int  (cas_int),
    .lane_oe  (lane_oe),
    .lane_wr  (lane_wr),
    .cyc_type (cyc_type),
    .mode_err (mode_err)
);

// File: tb/fpmx_decoder_bench.sv
`timescale 1ns/1ps
module fpmx_decoder_bench;
    // stimulus bit positions (active high in the bench)
    localparam int B_RAS = 4;
    localparam int B_CH  = 3;
    localparam int B_CL  = 2;
    localparam int B_WE  = 1;
    localparam int B_OE  = 0;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ras_n = 1'b1, casl_n = 1'b1, cash_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic       cas_int;
    logic [1:0] lane_oe;
    logic [1:0] lane_wr;
    logic [2:0] cyc_type;
    logic       mode_err;

    int total = 0;
    int bad   = 0;

    // reference model state
    logic [4:0] h0 = '0, h1 = '0, h2 = '0, h3 = '0;
    int         m_mode [2];
    logic       m_cas, m_err;
    logic [1:0] m_oe, m_wr;
    int         m_cyc;

    always #10 clk = ~clk;

    fpmx_decoder u_fpmx_decoder (
        .clk(clk), .rst(rst), .ras_n(ras_n), .casl_n(casl_n), .cash_n(cash_n),
        .we_n(we_n), .oe_n(oe_n), .cas_int(cas_int), .lane_oe(lane_oe),
        .lane_wr(lane_wr), .cyc_type(cyc_type), .mode_err(mode_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic model_reset();
        m_mode[0] = 0; m_mode[1] = 0;
        m_cas = 0; m_err = 0; m_oe = 0; m_wr = 0; m_cyc = 0;
    endtask

    // modes: 0 none, 1 read, 2 early write, 3 read-write
    task automatic model_step(input logic [4:0] c, input logic [4:0] p);
        logic row;
        logic cas_c, cas_p;
        row   = c[B_RAS] && p[B_RAS];
        cas_c = c[B_CL] || c[B_CH];
        cas_p = p[B_CL] || p[B_CH];
        m_cas = cas_c;
        for (int i = 0; i < 2; i++) begin
            logic on, was;
            on  = (i == 0) ? c[B_CL] : c[B_CH];
            was = (i == 0) ? p[B_CL] : p[B_CH];
            m_wr[i] = 1'b0;
            if (!on) m_mode[i] = 0;
            else if (!was) begin
                if (!row) m_mode[i] = 0;
                else if (c[B_WE]) begin m_mode[i] = 2; m_wr[i] = 1'b1; end
                else m_mode[i] = 1;
            end else if (m_mode[i] == 1 && c[B_WE] && !p[B_WE]) begin
                m_mode[i] = 3; m_wr[i] = 1'b1;
            end
            m_oe[i] = on && c[B_OE] && (m_mode[i] == 1 || m_mode[i] == 3);
        end
        m_err = (m_mode[0] != 0) && (m_mode[1] != 0) && ((m_mode[0] == 2) != (m_mode[1] == 2));
        if (!c[B_RAS]) m_cyc = 0;
        else if (!p[B_RAS]) m_cyc = cas_c ? 5 : 4;
        else if (m_cyc != 5 && cas_c && !cas_p) m_cyc = c[B_WE] ? 2 : 1;
        else if (m_cyc == 1 && cas_c && cas_p && c[B_WE] && !p[B_WE]) m_cyc = 3;
    endtask

    task automatic compare_model();
        chk("R1", "cas_int", int'(cas_int), int'(m_cas));
        chk("R5", "lane_oe", int'(lane_oe), int'(m_oe));
        chk("R3", "lane_wr", int'(lane_wr), int'(m_wr));
        chk("R9", "cyc_type", int'(cyc_type), m_cyc);
        chk("R7", "mode_err", int'(mode_err), int'(m_err));
    endtask

    task automatic cycle(input logic [4:0] v);
        @(negedge clk);
        compare_model();
        ras_n = ~v[B_RAS]; cash_n = ~v[B_CH]; casl_n = ~v[B_CL];
        we_n = ~v[B_WE]; oe_n = ~v[B_OE];
        h3 = h2; h2 = h1; h1 = h0; h0 = v;
        @(posedge clk);
        #1;
        model_step(h2, h3);
    endtask

    task automatic hold(input logic [4:0] v, input int n);
        for (int k = 0; k < n; k++) cycle(v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk("R11", "cas_int", int'(cas_int), 0);
        chk("R11", "lane_oe", int'(lane_oe), 0);
        chk("R11", "lane_wr", int'(lane_wr), 0);
        chk("R11", "cyc_type", int'(cyc_type), 0);
        chk("R11", "mode_err", int'(mode_err), 0);

        hold(5'b00000, 3);
        // R8 RAS-only
        hold(5'b10000, 4);
        chk("R8", "ras only", int'(cyc_type), 4);
        // R10 latency of lower-lane read
        hold(5'b10101, 2);
        chk("R10", "cas_int after 2 edges", int'(cas_int), 0);
        cycle(5'b10101);
        chk("R10", "cas_int after 3 edges", int'(cas_int), 1);
        hold(5'b10101, 2);
        chk("R2", "byte read lane", int'(lane_oe), 1);
        chk("R9", "read class", int'(cyc_type), 1);
        hold(5'b11101, 4);
        chk("R2", "word read lanes", int'(lane_oe), 3);
        hold(5'b11100, 4);
        chk("R6", "oe high", int'(lane_oe), 0);
        hold(5'b11101, 4);
        // R5 late write
        hold(5'b11111, 3);
        chk("R3", "late write pulse", int'(lane_wr), 3);
        cycle(5'b11111);
        chk("R3", "late write pulse end", int'(lane_wr), 0);
        chk("R5", "rd_wr drive", int'(lane_oe), 3);
        chk("R5", "rd_wr class", int'(cyc_type), 3);
        hold(5'b00000, 4);
        // R4 early word write
        hold(5'b10000, 4);
        hold(5'b10010, 4);
        hold(5'b11111, 4);
        chk("R4", "early write no drive", int'(lane_oe), 0);
        chk("R9", "early class", int'(cyc_type), 2);
        hold(5'b00000, 4);
        // R7 mixed modes
        hold(5'b10000, 4);
        hold(5'b10101, 4);
        hold(5'b10111, 4);
        hold(5'b11111, 4);
        chk("R7", "mixed modes", int'(mode_err), 1);
        chk("R2", "lower still drives", int'(lane_oe), 1);
        hold(5'b00000, 4);
        // R8 CBR, no lane enabled
        hold(5'b00101, 4);
        chk("R6", "strobe without row", int'(lane_oe), 0);
        hold(5'b10101, 4);
        chk("R8", "cbr class", int'(cyc_type), 5);
        hold(5'b00000, 4);
        // hidden refresh keeps read drive
        hold(5'b10000, 4);
        hold(5'b10101, 4);
        hold(5'b00101, 4);
        chk("R5", "drive across ras high", int'(lane_oe), 1);
        hold(5'b10101, 4);
        chk("R8", "hidden refresh class", int'(cyc_type), 5);
        chk("R5", "drive in hidden refresh", int'(lane_oe), 1);
        hold(5'b00000, 4);
        // R1 first fall to last rise
        hold(5'b00100, 4);
        hold(5'b01100, 4);
        hold(5'b01000, 4);
        chk("R1", "one lane still held", int'(cas_int), 1);
        hold(5'b00000, 4);
        chk("R1", "both released", int'(cas_int), 0);

        void'($urandom(32'd20240611));
        for (int n = 0; n < 2500; n++) begin
            logic [4:0] v;
            v = 5'($urandom());
            if (($urandom() % 4) != 0) v[B_RAS] = h0[B_RAS];
            hold(v, 1 + int'($urandom() % 4));
        end
        hold(5'b00000, 4);
        finish_run();
    end

endmodule